// File: doc/BRIEF.md
# PCM Voice Serial Port

This block connects the parallel sample interface of a voice codec core to a synchronous serial link that runs to a DSP. A bit clock and a frame sync come from outside. The block runs in a faster system clock domain and oversamples both lines. For each frame it sends one transmit word MSB first on a serial output and assembles one receive word from a serial input. When the receive word is complete it hands the word to the core together with a one-cycle strobe.

The framing mode selects how the frame sync relates to the data:

- **Delayed:** the first data bit comes one bit-clock period after the frame-sync period.
- **Non-delayed normal:** the first bit is launched on the same bit-clock edge that samples the frame sync.
- **Non-delayed reverse:** the launch and capture edges are swapped.

A word is 16 bits for linear samples or 8 bits for companded samples. A port enable gates the whole slot. A truncation option drops the least significant bit in both directions.

The serial output is modelled as a data bit plus an output-enable bit. When the output enable is low the pad is in high impedance.

Top module: `pcm_voice_port`

## Requirements
- R1: While `rst_n` is low (synchronous), `dx_oe` and `rx_valid` are low on the next clock, and after reset no slot is active until a frame sync is seen.
- R2: Normal mode (`frame_mode` 1, and also code 3): the launch edge is a rising `mclk` and the capture edge is a falling `mclk`. The launch edge on which `fs` is high drives the first (most significant) bit.
- R3: Reverse mode (`frame_mode` 2): the launch edge is a falling `mclk` and the capture edge is a rising `mclk`. The falling edge on which `fs` is high drives the first bit.
- R4: Delayed mode (`frame_mode` 0): `dx_oe` stays low in the period that follows the launch edge where `fs` is high. The first bit is driven on the next launch edge.
- R5: `wide`=1 moves 16-bit words (`tx_word[15:0]`). `wide`=0 moves 8-bit words (`tx_word[7:0]`); the received byte is zero-extended into `rx_word`. The most significant bit always goes first.
- R6: With `enable` low, `dx_oe` stays low for the whole slot and `rx_valid` never pulses.
- R7: With `trunc7`=1, `dx_oe` is low during the last bit time of the word, and bit 0 of the delivered `rx_word` is 0 whatever `dr` carried.
- R8: `dx_oe` is low outside the slot. The slot ends at the first launch edge after the last bit, unless a new frame sync starts another slot on that edge.
- R9: `rx_valid` pulses high for exactly one clock, one clock after the capture edge of the word's last bit is detected. `rx_word` holds the assembled word from that cycle onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `mclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_mode | input | 2 | 0 delayed, 1 normal, 2 reverse, 3 treated as normal |
| wide | input | 1 | 1 = 16-bit word, 0 = 8-bit word |
| enable | input | 1 | Port enable for the slot |
| trunc7 | input | 1 | Drop the least significant bit in both directions |
| mclk | input | 1 | Serial bit clock, sampled by `clk` |
| fs | input | 1 | Frame sync, sampled on the launch edge |
| tx_word | input | 16 | Transmit sample, read when a slot starts |
| dr | input | 1 | Serial receive data |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Drive enable for `dx`; low means high impedance |
| rx_word | output | 16 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |

## Verification
An `mclk` edge is detected in the `clk` cycle in which its new level is first sampled. `dx` and `dx_oe` take their new values one clock after that detection. `rx_valid` rises one clock after the capture edge of the last bit.

The bench changes `mclk`, `fs` and `dr` only on falling `clk` edges. After each change it waits four clock cycles and then samples `dx` and `dx_oe`, which is well after they have settled and before the next bit-clock edge. A monitor records every `rx_valid` pulse, so the pulse count and the received word are checked after the closing edge of the slot, without depending on the exact cycle in which the strobe appears.

// File: rtl/pcm_port_pkg.sv
// Shared types and constants for the PCM voice serial port.
package pcm_port_pkg;
    typedef enum logic [1:0] {
        FRM_DELAYED = 2'd0,
        FRM_NORMAL  = 2'd1,
        FRM_REVERSE = 2'd2,
        FRM_ALIAS   = 2'd3
    } frame_mode_e;
endpackage

// File: rtl/pcm_edge_detect.sv
// Detects rising and falling transitions of a slow level sampled by clk.
// Assumes the input is already synchronous to clk and holds each level for
// at least two clk cycles. The edge flags are combinational and valid in the
// cycle where the new level is first seen.
module pcm_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic din_q;

    // Remembers the previous sample; loads the current level in reset so that no false edge follows reset.
    always_ff @(posedge clk) begin
        din_q <= din;
    end

    assign rise = rst_n && din && !din_q;
    assign fall = rst_n && !din && din_q;
endmodule

// File: rtl/pcm_slot_timer.sv
// Tracks the single time slot: start on frame sync (immediate or one period
// late), bit index, and the end of the slot at the launch edge after the
// last bit. Assumes launch and capture flags are never high together.
module pcm_slot_timer #(
    parameter int WIDE_BITS   = 16,
    parameter int NARROW_BITS = 8,
    localparam int CW         = $clog2(WIDE_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          fs,
    input  logic          delayed,
    input  logic          wide,
    output logic          start,
    output logic          active,
    output logic          last,
    output logic [CW-1:0] bit_idx
);
    logic          pending;
    logic [CW-1:0] len_m1;

    assign len_m1 = wide ? CW'(WIDE_BITS - 1) : CW'(NARROW_BITS - 1);
    assign start  = launch && ((fs && !delayed) || (!fs && pending));
    assign last   = active && (bit_idx == len_m1);

    // Slot state: arm on a delayed sync, start, advance one bit per launch, close after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            pending <= 1'b0;
            bit_idx <= '0;
        end else if (launch) begin
            if (start) begin
                active  <= 1'b1;
                pending <= 1'b0;
                bit_idx <= '0;
            end else if (fs) begin
                active  <= 1'b0;
                pending <= 1'b1;
            end else if (last) begin
                active  <= 1'b0;
            end else if (active) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    assert_bit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_idx <= len_m1));

    assert_delay_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && fs && delayed) |=> !active);
endmodule

// File: rtl/pcm_tx_shifter.sv
// Loads the transmit word when a slot starts and presents it MSB first, one
// bit per launch edge. Assumes tx_word is stable around the start edge.
// Drives the output enable from the slot state, enable and truncation.
module pcm_tx_shifter #(
    parameter int WIDE_BITS   = 16,
    parameter int NARROW_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 launch,
    input  logic                 active,
    input  logic                 last,
    input  logic                 enable,
    input  logic                 trunc7,
    input  logic                 wide,
    input  logic [WIDE_BITS-1:0] tx_word,
    output logic                 dx,
    output logic                 dx_oe
);
    localparam int PAD = WIDE_BITS - NARROW_BITS;

    logic [WIDE_BITS-1:0] shreg;
    logic [WIDE_BITS-1:0] load_val;

    assign load_val = wide ? tx_word : {tx_word[NARROW_BITS-1:0], {PAD{1'b0}}};

    // Shift register: load on slot start, shift left on each later launch edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (start) begin
            shreg <= load_val;
        end else if (launch && active) begin
            shreg <= {shreg[WIDE_BITS-2:0], 1'b0};
        end
    end

    assign dx    = shreg[WIDE_BITS-1];
    assign dx_oe = enable && active && !(trunc7 && last);
endmodule

// File: rtl/pcm_rx_shifter.sv
// Shifts serial receive bits in on capture edges and delivers the word with
// a one-cycle strobe after the last bit. Assumes at least one non-capture
// cycle between capture edges. A narrow word is zero-extended; truncation
// clears bit 0.
module pcm_rx_shifter #(
    parameter int WIDE_BITS   = 16,
    parameter int NARROW_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic                 active,
    input  logic                 last,
    input  logic                 enable,
    input  logic                 wide,
    input  logic                 trunc7,
    input  logic                 dr,
    output logic [WIDE_BITS-1:0] rx_word,
    output logic                 rx_valid
);
    localparam int PAD = WIDE_BITS - NARROW_BITS;

    logic [WIDE_BITS-1:0] shreg;
    logic [WIDE_BITS-1:0] assembled;
    logic [WIDE_BITS-1:0] sized;
    logic                 take;

    assign take      = capture && active && enable;
    assign assembled = {shreg[WIDE_BITS-2:0], dr};
    assign sized     = wide ? assembled : {{PAD{1'b0}}, assembled[NARROW_BITS-1:0]};

    // Input shift register and word delivery with a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (take) begin
                shreg <= assembled;
                if (last) begin
                    rx_word  <= {sized[WIDE_BITS-1:1], sized[0] && !trunc7};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_valid_after_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(capture));
endmodule

// File: rtl/pcm_voice_port.sv
// Top of the PCM voice serial port. Maps the framing mode to launch and
// capture edges of the oversampled bit clock and joins the slot timer with
// the transmit and receive shifters. Assumes mclk and fs are synchronous to
// clk and that each mclk level lasts at least two clk cycles.
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int WIDE_BITS   = 16,
    parameter int NARROW_BITS = 8,
    localparam int CW         = $clog2(WIDE_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           frame_mode,
    input  logic                 wide,
    input  logic                 enable,
    input  logic                 trunc7,
    input  logic                 mclk,
    input  logic                 fs,
    input  logic [WIDE_BITS-1:0] tx_word,
    input  logic                 dr,
    output logic                 dx,
    output logic                 dx_oe,
    output logic [WIDE_BITS-1:0] rx_word,
    output logic                 rx_valid
);
    frame_mode_e   mode;
    logic          mclk_rise, mclk_fall;
    logic          reverse, delayed;
    logic          launch, capture;
    logic          start, active, last;
    logic [CW-1:0] bit_idx;

    assign mode    = frame_mode_e'(frame_mode);
    assign reverse = (mode == FRM_REVERSE);
    assign delayed = (mode == FRM_DELAYED);
    assign launch  = reverse ? mclk_fall : mclk_rise;
    assign capture = reverse ? mclk_rise : mclk_fall;

    pcm_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .din(mclk), .rise(mclk_rise), .fall(mclk_fall)
    );

    pcm_slot_timer #(.WIDE_BITS(WIDE_BITS), .NARROW_BITS(NARROW_BITS)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .fs(fs), .delayed(delayed),
        .wide(wide), .start(start), .active(active), .last(last), .bit_idx(bit_idx)
    );

    pcm_tx_shifter #(.WIDE_BITS(WIDE_BITS), .NARROW_BITS(NARROW_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .launch(launch), .active(active),
        .last(last), .enable(enable), .trunc7(trunc7), .wide(wide),
        .tx_word(tx_word), .dx(dx), .dx_oe(dx_oe)
    );

    pcm_rx_shifter #(.WIDE_BITS(WIDE_BITS), .NARROW_BITS(NARROW_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .capture(capture), .active(active), .last(last),
        .enable(enable), .wide(wide), .trunc7(trunc7), .dr(dr),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rx_valid && !active));

    assert_trunc_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(trunc7)) |-> !rx_word[0]);

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!enable) && !enable) |-> !rx_valid);
endmodule

// File: tb/pcm_voice_port_test.sv
// Self-checking bench: a vector table of frames, then directed reset tests.
module pcm_voice_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  frame_mode = 2'd1;
    logic        wide = 1'b1, enable = 1'b0, trunc7 = 1'b0;
    logic        mclk = 1'b0, fs = 1'b0, dr = 1'b0;
    logic [15:0] tx_word = '0;
    logic        dx, dx_oe, rx_valid;
    logic [15:0] rx_word;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [15:0] vword = '0;

    always #4 clk = ~clk;

    pcm_voice_port uut (
        .clk(clk), .rst_n(rst_n), .frame_mode(frame_mode), .wide(wide),
        .enable(enable), .trunc7(trunc7), .mclk(mclk), .fs(fs),
        .tx_word(tx_word), .dr(dr), .dx(dx), .dx_oe(dx_oe),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    // Records every strobe and the word delivered with it.
    always @(posedge clk) begin
        if (rst_n && rx_valid) begin
            vcount <= vcount + 1;
            vword  <= rx_word;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // {mode[1:0], wide, enable, trunc7, tx[15:0], rx[15:0]}
    localparam logic [36:0] VEC [8] = '{
        {2'd1, 1'b1, 1'b1, 1'b0, 16'hA5C3, 16'h3C5A},
        {2'd2, 1'b1, 1'b1, 1'b0, 16'h8001, 16'h7FFE},
        {2'd0, 1'b1, 1'b1, 1'b0, 16'h1234, 16'hFEDC},
        {2'd1, 1'b0, 1'b1, 1'b0, 16'h12D6, 16'h00B9},
        {2'd2, 1'b0, 1'b1, 1'b1, 16'h00A7, 16'h0055},
        {2'd0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF},
        {2'd0, 1'b0, 1'b1, 1'b1, 16'h0081, 16'h00FF},
        {2'd3, 1'b1, 1'b1, 1'b0, 16'h0F0F, 16'hF0F0}
    };

    int          len;
    int          bad;
    logic        lv;
    logic [15:0] txw, rxw;

    // Checks dx_oe and dx for bit i of the current word.
    task automatic bit_check(input int i);
        logic exp_oe;
        exp_oe = enable && !(trunc7 && i == len - 1);
        if (dx_oe !== exp_oe) bad++;
        else if (exp_oe && dx !== txw[len-1-i]) bad++;
    endtask

    task automatic run_frame(input logic [36:0] v);
        string req;
        logic  dly;
        logic [15:0] exp_rx;
        @(negedge clk);
        frame_mode = v[36:35]; wide = v[34]; enable = v[33]; trunc7 = v[32];
        tx_word = v[31:16];
        lv  = (v[36:35] == 2'd2) ? 1'b0 : 1'b1;
        dly = (v[36:35] == 2'd0);
        len = v[34] ? 16 : 8;
        txw = v[34] ? v[31:16] : {8'h00, v[23:16]};
        rxw = v[34] ? v[15:0]  : {8'h00, v[7:0]};
        req = dly ? "R4" : ((v[36:35] == 2'd2) ? "R3" : "R2");
        mclk = ~lv; fs = 1'b0;
        settle(); settle();
        vcount = 0; bad = 0;
        // launch edge with frame sync
        @(negedge clk); mclk = lv; fs = 1'b1; dr = dly ? 1'b0 : rxw[len-1];
        settle();
        if (dly) chk("R4 dx_oe during sync period", 32'(dx_oe), 32'd0);
        else bit_check(0);
        @(negedge clk); mclk = ~lv; fs = 1'b0;
        settle();
        for (int i = (dly ? 0 : 1); i < len; i++) begin
            @(negedge clk); mclk = lv; dr = rxw[len-1-i];
            settle();
            bit_check(i);
            @(negedge clk); mclk = ~lv;
            settle();
        end
        chk({req, "/R5/R7 serial bit errors"}, 32'(bad), 32'd0);
        // closing launch edge
        @(negedge clk); mclk = lv; dr = 1'b0;
        settle();
        chk("R8 dx_oe after slot", 32'(dx_oe), 32'd0);
        @(negedge clk); mclk = ~lv;
        settle();
        if (enable) begin
            exp_rx = trunc7 ? (rxw & 16'hFFFE) : rxw;
            chk("R9 strobe count", 32'(vcount), 32'd1);
            chk("R5/R7 received word", 32'(vword), 32'(exp_rx));
        end else begin
            chk("R6 no strobe when disabled", 32'(vcount), 32'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 dx_oe in reset", 32'(dx_oe), 32'd0);
        chk("R1 rx_valid in reset", 32'(rx_valid), 32'd0);
        rst_n = 1'b1;
        settle();
        chk("R1 idle after reset", 32'(dx_oe), 32'd0);

        for (int k = 0; k < 8; k++) run_frame(VEC[k]);

        // Directed: reset in the middle of an enabled normal-mode slot (R1).
        @(negedge clk);
        frame_mode = 2'd1; wide = 1'b1; enable = 1'b1; trunc7 = 1'b0;
        tx_word = 16'hFFFF; mclk = 1'b0;
        settle();
        @(negedge clk); mclk = 1'b1; fs = 1'b1;
        settle();
        chk("R2 slot opened", 32'(dx_oe), 32'd1);
        @(negedge clk); rst_n = 1'b0; fs = 1'b0;
        @(negedge clk);
        chk("R1 dx_oe after mid-slot reset", 32'(dx_oe), 32'd0);
        @(negedge clk); rst_n = 1'b1; mclk = 1'b0;
        settle();
        @(negedge clk); mclk = 1'b1;
        settle();
        chk("R1 no slot without new sync", 32'(dx_oe), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule